// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the clock line of an I2C controller. A reference clock is first divided by a programmable prescaler, and the resulting tick is the unit for three programmable counts: how long SCL is pulled low, how long SCL is counted high, and how long a whole SCL period lasts. A full period may be longer than the sum of the low and high counts. The extra ticks are spent with the line released, before the high count begins, so that a slow rising edge has time to settle.

A bus sequencer starts and stops the generator. It uses three single-cycle strobes to decide when to change or sample SDA: one at the start of the counted high time, one near its middle, and one where SCL is pulled low again. START and STOP conditions stay with the sequencer. A target that holds SCL low (clock stretching) simply delays the start of the high count. This lengthens the period and is not treated as an error. The divider and the counts are captured when a run starts and do not change until the next start.

Top module: `i2c_scl_pacer`

## Requirements
- R1: The prescaler produces one tick every `cfg_div` reference clocks. A divider of 0 behaves exactly like a divider of 1. All phase counts below are in ticks.
- R2: In every SCL period the generator holds `scl_drive_low` high for L ticks. L is the field `cfg_counts[19:10]`, and a value of 0 counts as 1.
- R3: From `rise_stb` to the following `fall_stb`, H ticks elapse. H is the field `cfg_counts[29:20]`, and a value of 0 counts as 1.
- R4: Consecutive `fall_stb` pulses are (L + G + H) ticks apart. C is the field `cfg_counts[9:0]`. G = C − H − L when C > H + L, otherwise G = 1. This holds as long as the line reads high by the end of the G ticks.
- R5: `mid_stb` pulses ceil(H/2) ticks after `rise_stb`.
- R6: When the synchronised `scl_in` still reads low at the end of the released interval, high counting waits for the first tick at which it reads high. The high time stays H ticks and the period grows by the extra wait.
- R7: In idle, `run_req` captures `cfg_div` and `cfg_counts`. On the next cycle `busy` and `scl_drive_low` are high. The first low phase after a start has no `fall_stb`.
- R8: While busy, changes on `cfg_div` or `cfg_counts`, and further `run_req` pulses, have no effect. New values are used only at the next start.
- R9: After `halt_req` during a run, the current period is completed up to the end of its high time. At that point `busy` drops exactly where the next `fall_stb` would have come. SCL is left released, and no `fall_stb` is issued.
- R10: After reset the block is idle: `busy` is low, SCL is released and all strobes are low.
- R11: Every strobe is one cycle wide and appears on the cycle after its phase change. `fall_stb` coincides with the first cycle of `scl_drive_low`. `rise_stb` and `fall_stb` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Prescaler divider (0 acts as 1) |
| cfg_counts | input | 3*CNT_W | Packed counts: high [29:20], low [19:10], period [9:0] |
| run_req | input | 1 | Start request from the sequencer (used in idle only) |
| halt_req | input | 1 | Stop request: finish the current period's high time, then go idle |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | Open-drain enable: 1 pulls SCL low |
| busy | output | 1 | Generator is running |
| rise_stb | output | 1 | Start of the counted high time |
| mid_stb | output | 1 | Middle of the high time (SDA sample point) |
| fall_stb | output | 1 | SCL pulled low again (SDA change point) |

## Verification
The bench builds the block with its defaults: an 8-bit divider, 10-bit counts and a two-stage line synchroniser. These widths cover the three standard bus rates exactly, together with the edge cases of a zero divider, zero high and low counts, and a period shorter than high plus low. The line model is the open-drain wire itself, so the two-cycle synchroniser delay is part of every measured period. The rates with a one-clock tick and the shortest released intervals then show whether the released interval is long enough to absorb that delay. A held-low line in the same model exercises stretching, checking that the high time is unchanged while the period grows.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_GAP  = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // A programmed count of zero is stretched to one tick.
  function automatic int unsigned eff_count(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // Released ticks between the low phase and the counted high phase.
  function automatic int unsigned gap_ticks(input int unsigned hi_raw,
                                            input int unsigned lo_raw,
                                            input int unsigned cyc_raw);
    int unsigned h;
    int unsigned l;
    h = eff_count(hi_raw);
    l = eff_count(lo_raw);
    if (cyc_raw > h + l) return cyc_raw - h - l;
    return 1;
  endfunction

  // Ticks from the start of the high phase to the sample strobe.
  function automatic int unsigned mid_ticks(input int unsigned hi_raw);
    return (eff_count(hi_raw) + 1) / 2;
  endfunction

endpackage

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] last;

  assign last = (div_val == '0) ? '0 : div_val - DIV_W'(1);
  assign tick = run && (pcnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (restart) pcnt <= '0;
    else if (run)     pcnt <= (pcnt == last) ? '0 : pcnt + DIV_W'(1);
  end

  // R1
  pcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> pcnt <= last);

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last != '0) |=> !tick);

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_hi
);

  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '1;
    else        shreg <= STAGES'({shreg, line_in});
  end

  assign line_hi = shreg[STAGES-1];

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl import scl_pacer_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_req,
  input  logic               halt_req,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [3*CNT_W-1:0] cfg_counts,
  input  logic               tick,
  input  logic               line_hi,
  output logic               start_fire,
  output logic [DIV_W-1:0]   div_q,
  output logic               busy,
  output logic               drive_low,
  output logic               rise_stb,
  output logic               mid_stb,
  output logic               fall_stb
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  scl_phase_e       ph;
  logic [CNT_W-1:0] hi_q, lo_q, gap_q, mid_q, cnt;
  logic [CNT_W-1:0] hi_w, lo_w, cyc_w;
  logic             stop_pend, stop_now;
  logic             low_done, gap_reached, gap_done, mid_hit, high_done;

  assign cyc_w = cfg_counts[CNT_W-1:0];
  assign lo_w  = cfg_counts[2*CNT_W-1:CNT_W];
  assign hi_w  = cfg_counts[3*CNT_W-1:2*CNT_W];

  // Named phase events, visible to the checks below.
  assign start_fire  = (ph == PH_IDLE) && run_req;
  assign stop_now    = stop_pend || halt_req;
  assign low_done    = (ph == PH_LOW)  && tick && (cnt == lo_q - ONE);
  assign gap_reached = (cnt >= gap_q - ONE);
  assign gap_done    = (ph == PH_GAP)  && tick && gap_reached && line_hi;
  assign mid_hit     = (ph == PH_HIGH) && tick && (cnt == mid_q - ONE);
  assign high_done   = (ph == PH_HIGH) && tick && (cnt == hi_q - ONE);

  assign busy      = (ph != PH_IDLE);
  assign drive_low = (ph == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      div_q     <= '0;
      hi_q      <= ONE;
      lo_q      <= ONE;
      gap_q     <= ONE;
      mid_q     <= ONE;
      stop_pend <= 1'b0;
      rise_stb  <= 1'b0;
      mid_stb   <= 1'b0;
      fall_stb  <= 1'b0;
    end else begin
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      mid_stb  <= mid_hit;
      if (busy && halt_req) stop_pend <= 1'b1;
      case (ph)
        PH_IDLE: begin
          if (run_req) begin
            div_q     <= cfg_div;
            hi_q      <= CNT_W'(eff_count(32'(hi_w)));
            lo_q      <= CNT_W'(eff_count(32'(lo_w)));
            gap_q     <= CNT_W'(gap_ticks(32'(hi_w), 32'(lo_w), 32'(cyc_w)));
            mid_q     <= CNT_W'(mid_ticks(32'(hi_w)));
            cnt       <= '0;
            stop_pend <= 1'b0;
            ph        <= PH_LOW;
          end
        end
        PH_LOW: begin
          if (low_done) begin
            cnt <= '0;
            ph  <= PH_GAP;
          end else if (tick) begin
            cnt <= cnt + ONE;
          end
        end
        PH_GAP: begin
          if (gap_done) begin
            cnt      <= '0;
            ph       <= PH_HIGH;
            rise_stb <= 1'b1;
          end else if (tick && !gap_reached) begin
            cnt <= cnt + ONE;
          end
        end
        PH_HIGH: begin
          if (high_done) begin
            cnt <= '0;
            if (stop_now) begin
              ph        <= PH_IDLE;
              stop_pend <= 1'b0;
            end else begin
              ph       <= PH_LOW;
              fall_stb <= 1'b1;
            end
          end else if (tick) begin
            cnt <= cnt + ONE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R6
  rise_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $past(line_hi));

  // R11
  fall_into_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> drive_low);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb}));

  // R7
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (drive_low && !fall_stb));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(div_q) && $stable(hi_q) && $stable(lo_q) && $stable(gap_q)));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!fall_stb && !drive_low));

endmodule

// File: rtl/i2c_scl_pacer.sv
module i2c_scl_pacer #(
  parameter int DIV_W       = 8,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [3*CNT_W-1:0] cfg_counts,
  input  logic               run_req,
  input  logic               halt_req,
  input  logic               scl_in,
  output logic               scl_drive_low,
  output logic               busy,
  output logic               rise_stb,
  output logic               mid_stb,
  output logic               fall_stb
);

  logic             tick;
  logic             line_hi;
  logic             start_fire;
  logic [DIV_W-1:0] div_q;

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (scl_in),
    .line_hi (line_hi)
  );

  scl_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_fire),
    .run     (busy),
    .div_val (div_q),
    .tick    (tick)
  );

  scl_phase_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_req    (run_req),
    .halt_req   (halt_req),
    .cfg_div    (cfg_div),
    .cfg_counts (cfg_counts),
    .tick       (tick),
    .line_hi    (line_hi),
    .start_fire (start_fire),
    .div_q      (div_q),
    .busy       (busy),
    .drive_low  (scl_drive_low),
    .rise_stb   (rise_stb),
    .mid_stb    (mid_stb),
    .fall_stb   (fall_stb)
  );

  // R10
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_drive_low && !rise_stb));

endmodule

// File: tb/sim_i2c_scl_pacer.sv
`timescale 1ns/1ps
module sim_i2c_scl_pacer;

  localparam int DIV_W = 8;
  localparam int CNT_W = 10;

  // Columns: divider, high, low, period, exp low clk, exp high clk, exp period clk, exp mid clk
  localparam int NV = 6;
  localparam int VEC [0:NV-1][0:7] = '{
    '{7, 10, 11, 26, 77, 70, 182, 35},
    '{2,  5, 12, 24, 24, 10,  48,  6},
    '{1,  3,  9, 18,  9,  3,  18,  2},
    '{4,  3,  4,  5, 16, 12,  32,  8},
    '{0,  2,  3,  9,  3,  2,   9,  1},
    '{3,  0,  0,  8,  3,  3,  24,  3}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [DIV_W-1:0]   cfg_div = '0;
  logic [3*CNT_W-1:0] cfg_counts = '0;
  logic               run_req = 1'b0;
  logic               halt_req = 1'b0;
  logic               hold = 1'b0;
  logic               scl_in;
  logic               scl_drive_low, busy, rise_stb, mid_stb, fall_stb;

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  int t_fall = 0, t_fall_prev = 0, t_rise = 0, t_mid = 0;
  int nfall = 0, nrise = 0;
  int low_run = 0, low_last = 0;

  always #5 clk = ~clk;

  assign scl_in = !scl_drive_low && !hold;

  i2c_scl_pacer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_div       (cfg_div),
    .cfg_counts    (cfg_counts),
    .run_req       (run_req),
    .halt_req      (halt_req),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .busy          (busy),
    .rise_stb      (rise_stb),
    .mid_stb       (mid_stb),
    .fall_stb      (fall_stb)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (fall_stb) begin
      t_fall_prev <= t_fall;
      t_fall      <= cyc;
      nfall       <= nfall + 1;
    end
    if (rise_stb) begin
      t_rise <= cyc;
      nrise  <= nrise + 1;
    end
    if (mid_stb) t_mid <= cyc;
    if (scl_drive_low) low_run <= low_run + 1;
    else if (low_run != 0) begin
      low_last <= low_run;
      low_run  <= 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic check_range(input string tag, input int act, input int lo, input int hi);
    nchk++;
    if (act < lo || act > hi) begin
      nfail++;
      $display("FAIL %s: act=%0d exp=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_falls(input int n);
    int target;
    target = nfall + n;
    while (nfall < target) step();
  endtask

  task automatic set_cfg(input int dv, input int hi, input int lo, input int cy);
    cfg_div    = DIV_W'(dv);
    cfg_counts = {CNT_W'(hi), CNT_W'(lo), CNT_W'(cy)};
  endtask

  task automatic pulse_run();
    run_req = 1'b1;
    step();
    run_req = 1'b0;
  endtask

  task automatic halt_and_check(input int exp_per, input string tag);
    int tf, nf, nr;
    tf = t_fall;
    nf = nfall;
    nr = nrise;
    halt_req = 1'b1;
    step();
    halt_req = 1'b0;
    while (busy) step();
    check({tag, " R9 idle timing"}, cyc - tf, exp_per);
    check({tag, " R9 no fall strobe"}, nfall, nf);
    check({tag, " R9 last high done"}, nrise, nr + 1);
    check({tag, " R9 line released"}, int'(scl_drive_low), 0);
  endtask

  initial begin
    repeat (4) step();
    // R10: reset state
    check("R10 busy", int'(busy), 0);
    check("R10 drive", int'(scl_drive_low), 0);
    check("R10 strobes", int'({rise_stb, mid_stb, fall_stb}), 0);
    rst_n = 1'b1;
    step();

    for (int v = 0; v < NV; v++) begin
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      pulse_run();
      // R7: low phase begins, no fall strobe on the first low
      check("R7 busy after start", int'(busy), 1);
      check("R7 low after start", int'(scl_drive_low), 1);
      check("R7 no fall at start", int'(fall_stb), 0);
      wait_falls(3);
      check("R4 period", t_fall - t_fall_prev, VEC[v][6]);
      check("R3 high", t_fall - t_rise, VEC[v][5]);
      check("R5 mid", t_mid - t_rise, VEC[v][7]);
      check("R2 low", low_last, VEC[v][4]);
      if (VEC[v][0] == 0) check("R1 zero divider period", t_fall - t_fall_prev, VEC[v][3]);
      halt_and_check(VEC[v][6], "vec");
      repeat (3) step();
    end

    // R8: configuration and start requests ignored while busy
    set_cfg(2, 5, 12, 24);
    pulse_run();
    wait_falls(1);
    set_cfg(7, 10, 11, 26);
    pulse_run();
    wait_falls(2);
    check("R8 period kept", t_fall - t_fall_prev, 48);
    check("R8 high kept", t_fall - t_rise, 10);
    halt_and_check(48, "R8");
    repeat (2) step();
    pulse_run();
    wait_falls(3);
    check("R8 new period at restart", t_fall - t_fall_prev, 182);
    halt_and_check(182, "R8b");
    repeat (2) step();

    // R6: clock stretching during the released interval
    set_cfg(2, 5, 12, 24);
    pulse_run();
    wait_falls(1);
    hold = 1'b1;
    while (scl_drive_low) step();
    repeat (40) step();
    hold = 1'b0;
    wait_falls(1);
    check("R6 high unchanged", t_fall - t_rise, 10);
    check("R6 mid unchanged", t_mid - t_rise, 6);
    check_range("R6 period stretched", t_fall - t_fall_prev, 74, 80);
    wait_falls(1);
    check("R6 next period nominal", t_fall - t_fall_prev, 48);
    halt_and_check(48, "R6");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R7 watchdog: act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule